// File: doc/BRIEF.md
# Interleaved Channel Address Translator

This block turns a 40-bit system address into the channel-local memory address that one memory channel sees. Eight programmable rules are held in the block, one for each interleave range. An outside decoder picks the range and gives the rule index with each request.

The chosen rule moves the part of the address at bit 16 and above by a signed offset. The offset is stored as a two's-complement value in units of 64 KiB, so that each channel's space becomes contiguous. The rule then removes the interleave-select bits among address bits 8, 7 and 6 and closes each gap by shifting the higher bits down. For 3-way and 6-way interleave it can also divide the remaining field by three. The result is memory address bits [36:6].

Requests and responses pass through a two-stage pipeline with valid/ready handshakes. The pipeline accepts one request per clock and keeps requests in order. A request whose rule holds an unsupported setting comes back flagged as a fault.

Top module: `chan_xlate_top`

## Requirements
- R1: After reset, all eight rules read as zero, `out_valid` is low and `in_ready` is high.
- R2: Rule k is written and read at byte address 0x80 + 4·k. Writes take effect when `cfg_we` is high. Rule bit 27 is the divide-by-3 flag. Bits 26, 25 and 24 select removal of address bits 8, 7 and 6. Bits 23:0 are the offset. A read returns bits 27:0 as stored, and bits 31:28 always read 0, whatever was written to them.
- R3: The intermediate address bits [39:16] equal `in_sysaddr[39:16]` plus the offset, taken modulo 2^24, which is the same as adding the sign-extended offset. Bits [15:6] pass through unchanged.
- R4: Each selected address bit (8, 7, 6) is removed, and every higher bit moves down one place for each bit removed below it.
- R5: When the divide-by-3 flag is set, the compacted field above bit 6 is replaced by its integer quotient by three.
- R6: `out_maddr` carries bits [36:6] of the final value. `out_maddr[0]` is address bit 6.
- R7: Only these settings of {divide-by-3, removal bits} are accepted: 0/000 (no interleave), 0/001 (2-way), 0/011 (4-way), 1/000 (3-way) and 1/001 (6-way). Any other setting gives `out_fault` = 1 with `out_maddr` = 0.
- R8: A rule whose offset bits 9:0 are not all zero gives `out_fault` = 1 with `out_maddr` = 0.
- R9: Responses leave in the order their requests were accepted. While `out_valid` is high and `out_ready` is low, the response holds steady. Whenever `out_valid` is low, `in_ready` is high.
- R10: A request accepted on clock edge k has `out_valid` high after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Rule register write strobe |
| cfg_addr | input | 8 | Rule register byte address |
| cfg_wdata | input | 32 | Rule register write data |
| cfg_rdata | output | 32 | Rule register read data for `cfg_addr` |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted this cycle when valid |
| in_range | input | 3 | Rule index for the request |
| in_sysaddr | input | 40 | System address |
| out_valid | output | 1 | Response present |
| out_ready | input | 1 | Consumer takes the response |
| out_fault | output | 1 | Rule held an unsupported setting |
| out_maddr | output | 31 | Memory address bits [36:6] |

## Verification
The hardest case to reach from the ports is a full pipeline under backpressure. Here both stages hold data, the output stalls, and `in_ready` must drop and then recover without losing or reordering a request. The stimulus holds `out_ready` low on about one cycle in four while `in_valid` stays high, and it leaves requests pending until they are accepted. Addresses with all upper bits set or all clear are mixed in with random ones, so the offset addition wraps in both directions. Every rule kind, including the faulting ones, is exercised in the same stream.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
    localparam int RULE_W  = 28;
    localparam int D3_BIT  = 27;
    localparam int RM_HI   = 26;
    localparam int RM_LO   = 24;
    localparam int RM_W    = RM_HI - RM_LO + 1;
    localparam int RSV_W   = 10;

    typedef enum logic [2:0] {
        RK_FLAT,
        RK_2WAY,
        RK_4WAY,
        RK_3WAY,
        RK_6WAY,
        RK_BAD
    } rule_kind_e;

    function automatic rule_kind_e classify(input logic d3, input logic [RM_W-1:0] rm);
        rule_kind_e k;
        unique case ({d3, rm})
            4'b0_000: k = RK_FLAT;
            4'b0_001: k = RK_2WAY;
            4'b0_011: k = RK_4WAY;
            4'b1_000: k = RK_3WAY;
            4'b1_001: k = RK_6WAY;
            default:  k = RK_BAD;
        endcase
        return k;
    endfunction
endpackage

// File: rtl/xlate_rule_bank.sv
module xlate_rule_bank
    import xlate_pkg::*;
#(
    parameter int NUM_RULES = 8,
    parameter int ADDR_W    = 8,
    parameter int BASE      = 'h80
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [31:0]                     wdata,
    output logic [31:0]                     rdata,
    output logic [NUM_RULES-1:0][RULE_W-1:0] rules
);
    localparam int IDX_W = $clog2(NUM_RULES);

    logic              hit;
    logic [IDX_W-1:0]  idx;

    always_comb begin
        idx = addr[IDX_W+1:2];
        hit = (addr[1:0] == 2'b00) &&
              ((addr >> (IDX_W + 2)) == ADDR_W'(BASE >> (IDX_W + 2)));
    end

    for (genvar g = 0; g < NUM_RULES; g++) begin : g_rule
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                rules[g] <= '0;
            else if (we && hit && idx == IDX_W'(g))
                rules[g] <= wdata[RULE_W-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        if (hit)
            rdata = {{(32-RULE_W){1'b0}}, rules[idx]};
    end
endmodule

// File: rtl/xlate_stage_a.sv
module xlate_stage_a
    import xlate_pkg::*;
#(
    parameter int SYS_W  = 40,
    parameter int OFF_W  = 24,
    parameter int OUT_LO = 6,
    parameter int UP_LO  = 16,
    localparam int VEC_W = SYS_W - OUT_LO
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              in_valid,
    input  logic [SYS_W-1:0]  sysaddr,
    input  logic [RULE_W-1:0] rule,
    output logic              s1_v,
    output logic [VEC_W-1:0]  s1_vec,
    output logic [RM_W-1:0]   s1_rm,
    output logic              s1_d3,
    output logic              s1_fault
);
    rule_kind_e          kind;
    logic [OFF_W-1:0]    off;
    logic [OFF_W-1:0]    upper;
    logic                bad;

    always_comb begin
        off   = rule[OFF_W-1:0];
        kind  = classify(rule[D3_BIT], rule[RM_HI:RM_LO]);
        bad   = (kind == RK_BAD) || (off[RSV_W-1:0] != '0);
        upper = sysaddr[SYS_W-1:UP_LO] + off;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_v     <= 1'b0;
            s1_vec   <= '0;
            s1_rm    <= '0;
            s1_d3    <= 1'b0;
            s1_fault <= 1'b0;
        end else if (load) begin
            s1_v     <= in_valid;
            s1_vec   <= {upper, sysaddr[UP_LO-1:OUT_LO]};
            s1_rm    <= rule[RM_HI:RM_LO];
            s1_d3    <= rule[D3_BIT];
            s1_fault <= bad;
        end
    end
endmodule

// File: rtl/xlate_stage_b.sv
module xlate_stage_b
    import xlate_pkg::*;
#(
    parameter int VEC_W = 34,
    parameter int OUT_W = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              s1_v,
    input  logic [VEC_W-1:0]  s1_vec,
    input  logic [RM_W-1:0]   s1_rm,
    input  logic              s1_d3,
    input  logic              s1_fault,
    output logic              s2_v,
    output logic              s2_fault,
    output logic [OUT_W-1:0]  s2_addr
);
    logic [VEC_W-1:0] packed_v;
    logic [VEC_W-1:0] final_v;

    always_comb begin
        packed_v = s1_vec;
        for (int k = RM_W - 1; k >= 0; k--) begin
            if (s1_rm[k])
                packed_v = ((packed_v >> (k + 1)) << k) |
                           (packed_v & ((VEC_W'(1) << k) - VEC_W'(1)));
        end
        final_v = s1_d3 ? (packed_v / VEC_W'(3)) : packed_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_v     <= 1'b0;
            s2_fault <= 1'b0;
            s2_addr  <= '0;
        end else if (load) begin
            s2_v     <= s1_v;
            s2_fault <= s1_fault;
            s2_addr  <= s1_fault ? '0 : final_v[OUT_W-1:0];
        end
    end
endmodule

// File: rtl/chan_xlate_top.sv
module chan_xlate_top
    import xlate_pkg::*;
#(
    parameter int NUM_RULES = 8,
    parameter int SYS_W     = 40,
    parameter int OFF_W     = 24,
    parameter int OUT_LO    = 6,
    parameter int OUT_HI    = 36,
    parameter int CFG_AW    = 8,
    parameter int CFG_BASE  = 'h80,
    localparam int IDX_W    = $clog2(NUM_RULES),
    localparam int UP_LO    = SYS_W - OFF_W,
    localparam int VEC_W    = SYS_W - OUT_LO,
    localparam int OUT_W    = OUT_HI - OUT_LO + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [IDX_W-1:0]  in_range,
    input  logic [SYS_W-1:0]  in_sysaddr,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_fault,
    output logic [OUT_W-1:0]  out_maddr
);
    logic [NUM_RULES-1:0][RULE_W-1:0] rules;
    logic                 take_a, take_b;
    logic                 s1_v, s1_d3, s1_fault;
    logic [VEC_W-1:0]     s1_vec;
    logic [RM_W-1:0]      s1_rm;

    always_comb begin
        take_b   = !out_valid || out_ready;
        take_a   = !s1_v || take_b;
        in_ready = take_a;
    end

    xlate_rule_bank #(.NUM_RULES(NUM_RULES), .ADDR_W(CFG_AW), .BASE(CFG_BASE)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .rdata(cfg_rdata), .rules(rules)
    );

    xlate_stage_a #(.SYS_W(SYS_W), .OFF_W(OFF_W), .OUT_LO(OUT_LO), .UP_LO(UP_LO)) u_sa (
        .clk(clk), .rst_n(rst_n), .load(take_a), .in_valid(in_valid),
        .sysaddr(in_sysaddr), .rule(rules[in_range]),
        .s1_v(s1_v), .s1_vec(s1_vec), .s1_rm(s1_rm), .s1_d3(s1_d3), .s1_fault(s1_fault)
    );

    xlate_stage_b #(.VEC_W(VEC_W), .OUT_W(OUT_W)) u_sb (
        .clk(clk), .rst_n(rst_n), .load(take_b),
        .s1_v(s1_v), .s1_vec(s1_vec), .s1_rm(s1_rm), .s1_d3(s1_d3), .s1_fault(s1_fault),
        .s2_v(out_valid), .s2_fault(out_fault), .s2_addr(out_maddr)
    );
endmodule

// File: rtl/xlate_chk.sv
module xlate_chk #(
    parameter int OUT_W = 31
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic             out_fault,
    input logic [OUT_W-1:0] out_maddr,
    input logic [31:0]      cfg_rdata
);
    assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_maddr) && $stable(out_fault)));

    assert_ready_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    assert_two_cycle_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> ##1 out_valid);

    assert_fault_zero_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_fault) |-> (out_maddr == '0));

    assert_top_bits_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[31:28] == 4'b0000);
endmodule

bind chan_xlate_top xlate_chk #(.OUT_W(OUT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_fault(out_fault),
    .out_maddr(out_maddr), .cfg_rdata(cfg_rdata)
);

// File: tb/chan_xlate_top_test.sv
module chan_xlate_top_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [2:0]  in_range = '0;
    logic [39:0] in_sysaddr = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic        out_fault;
    logic [30:0] out_maddr;

    int total = 0;
    int bad = 0;

    logic [27:0] prog [8];
    logic [31:0] exp_q [$];
    int          rng_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    chan_xlate_top uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .in_valid(in_valid),
        .in_ready(in_ready), .in_range(in_range), .in_sysaddr(in_sysaddr),
        .out_valid(out_valid), .out_ready(out_ready), .out_fault(out_fault),
        .out_maddr(out_maddr)
    );

    function automatic logic [31:0] model(input logic [27:0] r, input logic [39:0] a);
        longint unsigned up, full, q;
        int rm;
        bit d3, ok;
        rm = int'(r[26:24]);
        d3 = r[27];
        up = ((longint'(a) >> 16) + longint'(r[23:0])) & 64'hFFFFFF;
        full = (up << 16) | (longint'(a) & 64'hFFFF);
        for (int b = 8; b >= 6; b--) begin
            if (rm[b-6])
                full = ((full >> (b + 1)) << b) | (full & ((64'd1 << b) - 1));
        end
        q = full >> 6;
        if (d3) q = q / 3;
        ok = d3 ? (rm == 0 || rm == 1) : (rm == 0 || rm == 1 || rm == 3);
        if (r[9:0] != 0) ok = 0;
        return ok ? {1'b0, q[30:0]} : {1'b1, 31'b0};
    endfunction

    function automatic string tag_for(input int r);
        case (r)
            0: return "R3,R6";
            1, 2: return "R4,R6";
            3, 4: return "R5,R6";
            6: return "R8";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    function automatic logic [39:0] pick_addr();
        case ($urandom % 6)
            0: return 40'hFF_FFFF_FFFF;
            1: return 40'h00_0000_0000;
            2: return {24'hFFFFFF, 16'($urandom)};
            default: return {8'($urandom), 32'($urandom)};
        endcase
    endfunction

    initial begin
        prog[0] = 28'h0000000;
        prog[1] = 28'h1FFFC00;
        prog[2] = 28'h3FFF000;
        prog[3] = 28'h8000400;
        prog[4] = 28'h9FF0000;
        prog[5] = 28'h2000000;
        prog[6] = 28'h0000001;
        prog[7] = 28'hB000000;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", out_valid, 0);
        check(in_ready == 1'b1, "R1", in_ready, 1);
        for (int k = 0; k < 8; k++) begin
            cfg_addr = 8'(8'h80 + 4 * k);
            #1;
            check(cfg_rdata == 32'd0, "R1", cfg_rdata, 0);
        end

        for (int k = 0; k < 8; k++)
            cfg_write(8'(8'h80 + 4 * k), {4'hF, prog[k]});
        for (int k = 0; k < 8; k++) begin
            cfg_addr = 8'(8'h80 + 4 * k);
            #1;
            check(cfg_rdata == {4'h0, prog[k]}, "R2", cfg_rdata, {4'h0, prog[k]});
        end

        // R10: single request into an idle pipeline
        @(negedge clk);
        out_ready = 1'b1;
        in_valid = 1'b1; in_range = 3'd3; in_sysaddr = 40'h12_3456_789A;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b0, "R10", out_valid, 0);
        @(negedge clk);
        check(out_valid == 1'b1, "R10", out_valid, 1);
        check({out_fault, out_maddr} == model(prog[3], 40'h12_3456_789A), "R10,R5",
              {out_fault, out_maddr}, model(prog[3], 40'h12_3456_789A));

        // random stream with backpressure
        @(negedge clk);
        begin
            bit hold = 0;
            for (int c = 0; c < 4000; c++) begin
                bit fire_in, fire_out;
                out_ready = ($urandom % 4) != 0;
                if (!hold) begin
                    in_valid = (c < 3900) && (($urandom % 5) != 0);
                    in_range = 3'($urandom % 8);
                    in_sysaddr = pick_addr();
                end
                #1;
                fire_in = in_valid && in_ready;
                fire_out = out_valid && out_ready;
                if (out_valid && exp_q.size() == 0)
                    check(0, "R9", 1, 0);
                if (fire_out && exp_q.size() != 0) begin
                    logic [31:0] e;
                    int r;
                    e = exp_q.pop_front();
                    r = rng_q.pop_front();
                    check({out_fault, out_maddr} == e, tag_for(r), {out_fault, out_maddr}, e);
                end
                if (fire_in) begin
                    exp_q.push_back(model(prog[in_range], in_sysaddr));
                    rng_q.push_back(int'(in_range));
                end
                hold = in_valid && !fire_in;
                @(negedge clk);
            end
        end
        check(exp_q.size() == 0, "R9", exp_q.size(), 0);
        summary();
    end
endmodule